// File: doc/BRIEF.md
# Byte-Wide Serial Port Register Emulator

This block presents the register interface of a classic byte-wide serial port controller to a host bus, with no physical serial line behind it. The host performs single-cycle, single-byte reads and writes at eight register offsets. Every byte written to the data register appears at once on a transmit stream. Bytes arriving on a receive stream are placed in a receive queue, and the host drains that queue through the data register.

The block maintains the interrupt identification and line status bits, and it emits a one-cycle interrupt pulse for each transmit-empty or receive event that is enabled. It also holds a divisor latch, a scratch register, and modem control and status registers. A loopback mode routes written bytes back into the receive queue, which holds up to 64 entries. No baud rate is generated and nothing is serialised.

Read data is combinational during the read strobe. All side effects, transmit output and interrupt pulses take effect at the clock edge that ends the strobe.

Top module: `uemu_regs`

## Requirements
- R1: After reset, the registers read as follows: offset 1 (interrupt enable) 0x00, offset 2 (interrupt identification) 0xC1, offset 3 (line control) 0x03, offset 4 (modem control) 0x08, offset 5 (line status) 0x60, offset 6 (modem status) 0xB0, offset 7 (scratch) 0x00, and the divisor 12. The tx_valid and irq outputs are low.
- R2: Offsets 3, 4 and 7 read back any byte written to them. Writes to offsets 2, 5 and 6 change nothing. An address of 8 or higher reads 0, and a write to such an address has no effect.
- R3: A write to offset 1 (with bit 7 of line control clear) keeps only bits 3:0. Bit 0 enables the receive interrupt and bit 1 enables the transmit-empty interrupt.
- R4: While bit 7 of line control is set, offsets 0 and 1 access the low and high bytes of the 16-bit divisor instead of the data and interrupt enable registers. While that bit is set, no byte is transmitted and no byte is queued.
- R5: With loopback off, a data write drives tx_valid high with the byte on tx_data for the one cycle after the write edge. If the transmit-empty interrupt is enabled, the write also clears identification bit 0, sets identification bit 1 and pulses irq.
- R6: With loopback off, each rx_valid byte is queued and sets line status bit 0. If the receive interrupt is enabled, it also clears identification bit 0, sets identification bit 2 and pulses irq.
- R7: A data read returns the oldest queued byte and removes it, or returns 0 if the queue is empty. It clears identification bit 2 and restores the value 0x01 if no bit remains set. Line status bit 0 clears when the read empties the queue.
- R8: A read of offset 2 returns the identification bits ORed with 0xC0 and then resets them to 0x01. Bit 0 is set exactly when neither bit 1 nor bit 2 is set.
- R9: When modem control bit 4 (loopback) is set, a data write is queued through the receive path of R6 and is not transmitted, and bytes on rx_valid are dropped.
- R10: The queue holds at most 64 bytes. A loopback write or rx_valid byte that arrives when the queue is full is dropped without effect, and the oldest 64 bytes are kept in order.
- R11: If a data read and an incoming byte occur in the same cycle, the pop happens before the push. The read returns the older byte, and line status bit 0 stays set.
- R12: irq is a pulse of one cycle, produced only for an enabled event. When the enable bits are clear, irq stays low during transmit and receive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| host_wr | input | 1 | Single-cycle write strobe; takes priority if asserted together with host_rd |
| host_rd | input | 1 | Single-cycle read strobe |
| host_addr | input | ADDR_W (4) | Register offset |
| host_wdata | input | 8 | Write byte |
| host_rdata | output | 8 | Read byte, valid while host_rd is high; 0 otherwise |
| rx_valid | input | 1 | An incoming byte is present this cycle |
| rx_data | input | 8 | Incoming byte |
| tx_valid | output | 1 | An outgoing byte is present this cycle |
| tx_data | output | 8 | Outgoing byte |
| irq | output | 1 | Interrupt pulse |

## Verification
The bound assertions check several properties on every cycle. The identification bits must stay coherent, with "none pending" set exactly when no cause is set. Data ready must always match a non-empty queue, and the queue count must never exceed its depth. Every transmit pulse must trace back to a plain data write, every irq must coincide with a pending cause, and the queue must stay unchanged while loopback drops incoming bytes. The bench scenarios cover what those invariants cannot show. These are the actual byte values and their order, the reset values, the divisor aliasing, the ORed read value and the clear-on-read of identification, the drop at the 64-entry limit, and the pop-before-push ordering within one cycle.

// File: rtl/uemu_pkg.sv
package uemu_pkg;

  typedef enum logic [2:0] {
    SEL_DATA  = 3'd0,
    SEL_IEN   = 3'd1,
    SEL_IID   = 3'd2,
    SEL_LCTL  = 3'd3,
    SEL_MCTL  = 3'd4,
    SEL_LSTAT = 3'd5,
    SEL_MSTAT = 3'd6,
    SEL_SCR   = 3'd7
  } sel_e;

  // identification causes; none is set only when no cause is pending
  typedef struct packed {
    logic rx;
    logic thr;
    logic none;
  } iid_t;

  localparam iid_t       IID_IDLE    = '{rx: 1'b0, thr: 1'b0, none: 1'b1};
  localparam logic [7:0] RST_LCTL    = 8'h03;
  localparam logic [7:0] RST_MCTL    = 8'h08;
  localparam logic [15:0] RST_DIV    = 16'd12;
  localparam logic [7:0] MSTAT_VAL   = 8'hB0;
  localparam logic [7:0] LSTAT_FIXED = 8'h60;
  localparam logic [7:0] IID_RD_OR   = 8'hC0;
  localparam int         LCTL_DLAB   = 7;
  localparam int         MCTL_LOOP   = 4;
  localparam int         IEN_RX      = 0;
  localparam int         IEN_TX      = 1;

endpackage

// File: rtl/uemu_rxq.sv
module uemu_rxq #(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic [CW-1:0] count,
  output logic          full
);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] rd_ptr_q, rd_ptr_d, wr_ptr_q, wr_ptr_d;
  logic [CW-1:0] count_q, count_d;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    ptr_inc = (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_comb begin
    rd_ptr_d = rd_ptr_q;
    wr_ptr_d = wr_ptr_q;
    count_d  = count_q;
    if (pop) begin
      rd_ptr_d = ptr_inc(rd_ptr_q);
    end
    if (push) begin
      wr_ptr_d = ptr_inc(wr_ptr_q);
    end
    if (push && !pop) begin
      count_d = count_q + CW'(1);
    end else if (pop && !push) begin
      count_d = count_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      rd_ptr_q <= rd_ptr_d;
      wr_ptr_q <= wr_ptr_d;
      count_q  <= count_d;
    end
  end

  // storage carries no reset; entries are only read once written
  always_ff @(posedge clk) begin
    if (push) begin
      mem[wr_ptr_q] <= push_data;
    end
  end

  assign head  = mem[rd_ptr_q];
  assign count = count_q;
  assign full  = (count_q == CW'(DEPTH));

endmodule

// File: rtl/uemu_iid.sv
module uemu_iid
  import uemu_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rd_clear,
  input  logic data_taken,
  input  logic thr_fire,
  input  logic rx_fire,
  output iid_t iid,
  output logic irq
);

  iid_t iid_q, iid_d;
  logic irq_q, irq_d;

  // ordering: clear-on-read, then data pop, then new causes
  always_comb begin
    iid_d = iid_q;
    if (rd_clear) begin
      iid_d = IID_IDLE;
    end
    if (data_taken) begin
      iid_d.rx = 1'b0;
      if (iid_d == '0) begin
        iid_d = IID_IDLE;
      end
    end
    if (thr_fire) begin
      iid_d.thr  = 1'b1;
      iid_d.none = 1'b0;
    end
    if (rx_fire) begin
      iid_d.rx   = 1'b1;
      iid_d.none = 1'b0;
    end
    irq_d = thr_fire | rx_fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iid_q <= IID_IDLE;
      irq_q <= 1'b0;
    end else begin
      iid_q <= iid_d;
      irq_q <= irq_d;
    end
  end

  assign iid = iid_q;
  assign irq = irq_q;

endmodule

// File: rtl/uemu_regs.sv
module uemu_regs
  import uemu_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int RXQ_DEPTH = 64,
  localparam int QCW      = $clog2(RXQ_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  output logic              irq
);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign srst_n = rst_sync_q[1];

  logic [3:0]  ien_q;
  logic [7:0]  lctl_q, mctl_q, scr_q, tx_data_q;
  logic [15:0] div_q;
  logic        dready_q, dready_d, tx_valid_q;

  logic        in_range, wr_act, rd_act, dlab, loop;
  sel_e        sel;
  logic        wr_data, rd_data, tx_send, lb_push, ext_push, q_push, q_pop;
  logic [7:0]  q_push_data, q_head;
  logic [QCW-1:0] q_count;
  logic        q_full, q_empty;
  logic        en_ien, en_lctl, en_mctl, en_scr, en_div_lo, en_div_hi;
  iid_t        iid_q;

  assign in_range = (host_addr[ADDR_W-1:3] == '0);
  assign wr_act   = host_wr & in_range;
  assign rd_act   = host_rd & ~host_wr & in_range;
  assign sel      = sel_e'(host_addr[2:0]);
  assign dlab     = lctl_q[LCTL_DLAB];
  assign loop     = mctl_q[MCTL_LOOP];
  assign q_empty  = (q_count == '0);

  assign wr_data  = wr_act & (sel == SEL_DATA) & ~dlab;
  assign rd_data  = rd_act & (sel == SEL_DATA) & ~dlab;
  assign tx_send  = wr_data & ~loop;
  assign q_pop    = rd_data & ~q_empty;
  assign lb_push  = wr_data & loop & ~q_full;
  assign ext_push = rx_valid & ~loop & (~q_full | q_pop);
  assign q_push   = lb_push | ext_push;
  assign q_push_data = lb_push ? host_wdata : rx_data;

  assign en_ien    = wr_act & (sel == SEL_IEN) & ~dlab;
  assign en_div_lo = wr_act & (sel == SEL_DATA) & dlab;
  assign en_div_hi = wr_act & (sel == SEL_IEN) & dlab;
  assign en_lctl   = wr_act & (sel == SEL_LCTL);
  assign en_mctl   = wr_act & (sel == SEL_MCTL);
  assign en_scr    = wr_act & (sel == SEL_SCR);

  uemu_rxq #(.DEPTH(RXQ_DEPTH), .DW(8)) i_rxq (
    .clk       (clk),
    .rst_n     (srst_n),
    .push      (q_push),
    .push_data (q_push_data),
    .pop       (q_pop),
    .head      (q_head),
    .count     (q_count),
    .full      (q_full)
  );

  uemu_iid i_iid (
    .clk        (clk),
    .rst_n      (srst_n),
    .rd_clear   (rd_act & (sel == SEL_IID)),
    .data_taken (rd_data),
    .thr_fire   (tx_send & ien_q[IEN_TX]),
    .rx_fire    (q_push & ien_q[IEN_RX]),
    .iid        (iid_q),
    .irq        (irq)
  );

  // data ready: pop first, then any push of the same cycle
  always_comb begin
    dready_d = dready_q;
    if (rd_data && q_count <= QCW'(1)) begin
      dready_d = 1'b0;
    end
    if (q_push) begin
      dready_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      ien_q      <= '0;
      lctl_q     <= RST_LCTL;
      mctl_q     <= RST_MCTL;
      scr_q      <= '0;
      div_q      <= RST_DIV;
      dready_q   <= 1'b0;
      tx_valid_q <= 1'b0;
      tx_data_q  <= '0;
    end else begin
      if (en_ien)    ien_q       <= host_wdata[3:0];
      if (en_lctl)   lctl_q      <= host_wdata;
      if (en_mctl)   mctl_q      <= host_wdata;
      if (en_scr)    scr_q       <= host_wdata;
      if (en_div_lo) div_q[7:0]  <= host_wdata;
      if (en_div_hi) div_q[15:8] <= host_wdata;
      if (tx_send)   tx_data_q   <= host_wdata;
      dready_q   <= dready_d;
      tx_valid_q <= tx_send;
    end
  end

  always_comb begin
    host_rdata = 8'h00;
    if (rd_act) begin
      unique case (sel)
        SEL_DATA:  host_rdata = dlab ? div_q[7:0] : (q_empty ? 8'h00 : q_head);
        SEL_IEN:   host_rdata = dlab ? div_q[15:8] : {4'h0, ien_q};
        SEL_IID:   host_rdata = IID_RD_OR | {5'b0, iid_q};
        SEL_LCTL:  host_rdata = lctl_q;
        SEL_MCTL:  host_rdata = mctl_q;
        SEL_LSTAT: host_rdata = LSTAT_FIXED | {7'b0, dready_q};
        SEL_MSTAT: host_rdata = MSTAT_VAL;
        SEL_SCR:   host_rdata = scr_q;
        default:   host_rdata = 8'h00;
      endcase
    end
  end

  assign tx_valid = tx_valid_q;
  assign tx_data  = tx_data_q;

endmodule

// File: rtl/uemu_chk.sv
module uemu_chk #(
  parameter int DEPTH  = 64,
  parameter int CW     = 7,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              srst_n,
  input logic              host_wr,
  input logic              host_rd,
  input logic [ADDR_W-1:0] host_addr,
  input logic              dlab,
  input logic              loop,
  input logic              rx_valid,
  input logic              tx_valid,
  input logic              irq,
  input logic [2:0]        iid,
  input logic [CW-1:0]     q_count,
  input logic              dready
);

  assert_iid_coherent_R8: assert property (@(posedge clk) disable iff (!srst_n)
    iid[0] ? (iid[2:1] == 2'b00) : (iid[2:1] != 2'b00));

  assert_ready_matches_queue_R7: assert property (@(posedge clk) disable iff (!srst_n)
    dready == (q_count != '0));

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!srst_n)
    q_count <= CW'(DEPTH));

  assert_tx_from_data_write_R5: assert property (@(posedge clk) disable iff (!srst_n)
    tx_valid |-> $past(host_wr && host_addr == '0 && !dlab && !loop));

  assert_irq_has_cause_R12: assert property (@(posedge clk) disable iff (!srst_n)
    irq |-> !iid[0]);

  assert_loop_drops_input_R9: assert property (@(posedge clk) disable iff (!srst_n)
    (loop && rx_valid && !host_wr && !host_rd) |=> $stable(q_count));

endmodule

bind uemu_regs uemu_chk #(.DEPTH(RXQ_DEPTH), .CW(QCW), .ADDR_W(ADDR_W)) i_uemu_chk (
  .clk       (clk),
  .srst_n    (srst_n),
  .host_wr   (host_wr),
  .host_rd   (host_rd),
  .host_addr (host_addr),
  .dlab      (dlab),
  .loop      (loop),
  .rx_valid  (rx_valid),
  .tx_valid  (tx_valid),
  .irq       (irq),
  .iid       (iid_q),
  .q_count   (q_count),
  .dready    (dready_q)
);

// File: tb/test_uemu_regs.sv
module test_uemu_regs;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_wr = 1'b0;
  logic       host_rd = 1'b0;
  logic [3:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_data = '0;
  logic       tx_valid;
  logic [7:0] tx_data;
  logic       irq;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  uemu_regs i_uemu_regs (
    .clk, .rst_n, .host_wr, .host_rd, .host_addr, .host_wdata, .host_rdata,
    .rx_valid, .rx_data, .tx_valid, .tx_data, .irq
  );

  // {wr, addr, data, expected read, requirement number}
  localparam int NV = 34;
  localparam logic [24:0] VEC [NV] = '{
    {1'b0, 4'd1, 8'h00, 8'h00, 4'd1},  // R1
    {1'b0, 4'd2, 8'h00, 8'hC1, 4'd1},
    {1'b0, 4'd3, 8'h00, 8'h03, 4'd1},
    {1'b0, 4'd4, 8'h00, 8'h08, 4'd1},
    {1'b0, 4'd5, 8'h00, 8'h60, 4'd1},
    {1'b0, 4'd6, 8'h00, 8'hB0, 4'd1},
    {1'b0, 4'd7, 8'h00, 8'h00, 4'd1},
    {1'b0, 4'd0, 8'h00, 8'h00, 4'd7},  // R7 empty read
    {1'b1, 4'd7, 8'h5A, 8'h00, 4'd2},  // R2
    {1'b0, 4'd7, 8'h00, 8'h5A, 4'd2},
    {1'b1, 4'd4, 8'h0B, 8'h00, 4'd2},
    {1'b0, 4'd4, 8'h00, 8'h0B, 4'd2},
    {1'b1, 4'd4, 8'h08, 8'h00, 4'd2},
    {1'b1, 4'd1, 8'hFF, 8'h00, 4'd3},  // R3
    {1'b0, 4'd1, 8'h00, 8'h0F, 4'd3},
    {1'b1, 4'd3, 8'h83, 8'h00, 4'd4},  // R4
    {1'b0, 4'd3, 8'h00, 8'h83, 4'd4},
    {1'b0, 4'd0, 8'h00, 8'h0C, 4'd4},
    {1'b0, 4'd1, 8'h00, 8'h00, 4'd4},
    {1'b1, 4'd0, 8'h34, 8'h00, 4'd4},
    {1'b1, 4'd1, 8'h12, 8'h00, 4'd4},
    {1'b0, 4'd0, 8'h00, 8'h34, 4'd4},
    {1'b0, 4'd1, 8'h00, 8'h12, 4'd4},
    {1'b1, 4'd3, 8'h03, 8'h00, 4'd4},
    {1'b0, 4'd1, 8'h00, 8'h0F, 4'd4},
    {1'b1, 4'd2, 8'hFF, 8'h00, 4'd2},  // R2 ignored writes
    {1'b1, 4'd5, 8'h00, 8'h00, 4'd2},
    {1'b1, 4'd6, 8'h00, 8'h00, 4'd2},
    {1'b0, 4'd5, 8'h00, 8'h60, 4'd2},
    {1'b0, 4'd6, 8'h00, 8'hB0, 4'd2},
    {1'b0, 4'd2, 8'h00, 8'hC1, 4'd2},
    {1'b0, 4'd9, 8'h00, 8'h00, 4'd2},
    {1'b1, 4'd15, 8'hA5, 8'h00, 4'd2},
    {1'b0, 4'd7, 8'h00, 8'h5A, 4'd2}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // all tasks start and end 1 ns after a rising edge
  task automatic do_wr(input logic [3:0] a, input logic [7:0] d);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(posedge clk); #1;
    host_wr = 1'b0;
  endtask

  task automatic do_rd(input logic [3:0] a, input logic [7:0] exp, input string req);
    host_rd = 1'b1; host_addr = a;
    #2;
    chk(req, host_rdata, exp);
    @(posedge clk); #1;
    host_rd = 1'b0;
  endtask

  task automatic do_rx(input logic [7:0] d);
    rx_valid = 1'b1; rx_data = d;
    @(posedge clk); #1;
    rx_valid = 1'b0;
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog (all R) actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    chk("R1 tx_valid after reset", {7'b0, tx_valid}, 8'h00);
    chk("R1 irq after reset", {7'b0, irq}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [24:0] v;
      string tag;
      v = VEC[i];
      tag = $sformatf("R%0d table entry %0d", v[3:0], i);
      if (v[24]) do_wr(v[23:20], v[19:12]);
      else       do_rd(v[23:20], v[11:4], tag);
      chk({tag, " tx_valid"}, {7'b0, tx_valid}, 8'h00);
      chk({tag, " irq"}, {7'b0, irq}, 8'h00);
    end

    // R5: transmit with both enables set (IER = 0x0F)
    do_wr(4'd0, 8'h41);
    chk("R5 tx_valid", {7'b0, tx_valid}, 8'h01);
    chk("R5 tx_data", tx_data, 8'h41);
    chk("R5 irq", {7'b0, irq}, 8'h01);
    @(posedge clk); #1;
    chk("R12 irq one cycle", {7'b0, irq}, 8'h00);
    chk("R5 tx_valid one cycle", {7'b0, tx_valid}, 8'h00);
    do_rd(4'd2, 8'hC2, "R8 thr cause");
    do_rd(4'd2, 8'hC1, "R8 cleared by read");

    // R12: no pulse with enables clear
    do_wr(4'd1, 8'h00);
    do_wr(4'd0, 8'h42);
    chk("R12 tx_valid", {7'b0, tx_valid}, 8'h01);
    chk("R12 tx_data", tx_data, 8'h42);
    chk("R12 no irq", {7'b0, irq}, 8'h00);
    do_rd(4'd2, 8'hC1, "R12 iid idle");

    // R6: receive with receive interrupt enabled
    do_wr(4'd1, 8'h01);
    do_rx(8'h11);
    chk("R6 irq", {7'b0, irq}, 8'h01);
    do_rx(8'h22);
    do_rx(8'h33);
    do_rd(4'd5, 8'h61, "R6 data ready");
    do_rd(4'd2, 8'hC4, "R6 rx cause");
    do_rd(4'd2, 8'hC1, "R8 cleared");
    do_rd(4'd0, 8'h11, "R7 order 1");
    do_rd(4'd5, 8'h61, "R7 still ready");
    do_rd(4'd0, 8'h22, "R7 order 2");
    do_rd(4'd0, 8'h33, "R7 order 3");
    do_rd(4'd5, 8'h60, "R7 ready cleared");
    do_rd(4'd0, 8'h00, "R7 empty read");

    // R7: data read clears the rx cause
    do_rx(8'h44);
    do_rd(4'd0, 8'h44, "R7 pop");
    do_rd(4'd2, 8'hC1, "R7 iid back to idle");

    // R7: data read leaves thr cause pending
    do_wr(4'd1, 8'h03);
    do_wr(4'd0, 8'h50);
    chk("R5 irq thr", {7'b0, irq}, 8'h01);
    do_rx(8'h51);
    chk("R6 irq rx", {7'b0, irq}, 8'h01);
    do_rd(4'd0, 8'h51, "R7 pop with thr pending");
    do_rd(4'd2, 8'hC2, "R7 thr remains");

    // R11: same-cycle pop and push
    do_wr(4'd1, 8'h00);
    do_rx(8'h55);
    host_rd = 1'b1; host_addr = 4'd0; rx_valid = 1'b1; rx_data = 8'h66;
    #2;
    chk("R11 read older byte", host_rdata, 8'h55);
    @(posedge clk); #1;
    host_rd = 1'b0; rx_valid = 1'b0;
    do_rd(4'd5, 8'h61, "R11 ready kept");
    do_rd(4'd0, 8'h66, "R11 newer byte");
    do_rd(4'd5, 8'h60, "R11 drained");

    // R9: loopback
    do_wr(4'd1, 8'h01);
    do_wr(4'd4, 8'h18);
    do_rx(8'h77);
    chk("R9 rx dropped irq", {7'b0, irq}, 8'h00);
    do_rd(4'd5, 8'h60, "R9 rx dropped");
    do_wr(4'd0, 8'h61);
    chk("R9 no tx", {7'b0, tx_valid}, 8'h00);
    chk("R9 irq via receive path", {7'b0, irq}, 8'h01);
    do_wr(4'd0, 8'h62);
    do_rd(4'd4, 8'h18, "R9 mctl");
    do_rd(4'd6, 8'hB0, "R9 mstat");
    do_rd(4'd5, 8'h61, "R9 ready");
    do_rd(4'd0, 8'h61, "R9 loop byte 1");
    do_rd(4'd0, 8'h62, "R9 loop byte 2");
    do_rd(4'd5, 8'h60, "R9 empty");

    // R10: loopback cap
    do_wr(4'd1, 8'h00);
    for (int i = 0; i < 70; i++) do_wr(4'd0, 8'(i));
    do_rd(4'd5, 8'h61, "R10 ready at cap");
    for (int i = 0; i < 64; i++) do_rd(4'd0, 8'(i), $sformatf("R10 loop entry %0d", i));
    do_rd(4'd5, 8'h60, "R10 empty after 64");
    do_rd(4'd0, 8'h00, "R10 no extra entry");
    do_wr(4'd4, 8'h08);

    // R10: external input beyond cap
    for (int i = 0; i < 65; i++) do_rx(8'(8'h80 + i));
    for (int i = 0; i < 64; i++) do_rd(4'd0, 8'(8'h80 + i), $sformatf("R10 ext entry %0d", i));
    do_rd(4'd0, 8'h00, "R10 ext extra dropped");

    // R1: reset in mid-operation
    do_wr(4'd7, 8'h99);
    do_wr(4'd3, 8'h80);
    #2 rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    do_rd(4'd7, 8'h00, "R1 scratch after reset");
    do_rd(4'd3, 8'h03, "R1 lctl after reset");
    do_rd(4'd1, 8'h00, "R1 ien after reset");
    do_rd(4'd5, 8'h60, "R1 lstat after reset");
    do_wr(4'd3, 8'h80);
    do_rd(4'd0, 8'h0C, "R1 divisor low after reset");
    do_rd(4'd1, 8'h00, "R1 divisor high after reset");

    summary();
    $finish;
  end

endmodule